// File: doc/BRIEF.md
# Addressed Serial Display and Key Port

This block is the host-facing serial slave of a display-and-keypad controller. The host frames each transfer with a chip-enable line. While chip-enable is low it clocks in one 8-bit address byte. Raising chip-enable opens the data phase. The address picks one of two directions. A write transfer loads the segment pattern, the sleep control pair and a 10-bit dimmer value. A read transfer returns the scanned key matrix and a flag for a press seen in sleep.

Write data lands in holding registers only when chip-enable drops after the exact expected number of bits. Any other length leaves the outputs untouched. The serial data output is the level an open-drain pad would show, so 1 means released. Between transfers the same line signals that key data waits to be read. After a complete read, a one-cycle strobe tells the key scanner that its data has been consumed.

A display-hold input blanks the display. During hold, write transfers are still taken, so a valid image can be loaded before hold is released. The serial pins are sampled through synchronizers into the system clock domain.

Top module: `vsp_serial_port`

## Requirements
- R1: While `rst` is high, `seg_data`, `sleep_ctl` and `dim_val` are zero, `ser_dout` is 1, `disp_on` is 0 and `key_read_done` is 0.
- R2: Bits are shifted LSB first on rising `ser_clk` edges. A write transfer uses address 8EH (bit sequence 0,1,1,1,0,0,0,1) followed by exactly 94 data bits. On the falling `ser_ce` that ends it, data bit k (0-based, k<82) appears at `seg_data[k]`.
- R3: In a write transfer, data bits 82..83 become `sleep_ctl[0..1]` and data bits 84..93 become `dim_val[0..9]`, so the dimmer value is sent LSB first.
- R4: A write transfer with any data length other than 94 bits leaves `seg_data`, `sleep_ctl` and `dim_val` unchanged.
- R5: A transfer whose address byte is neither 8EH nor 8FH changes no output register and produces no `key_read_done`.
- R6: While `hold` is high, `disp_on` is 0, yet write transfers still update the registers. `disp_on` returns to 1 once `hold` is low.
- R7: Outside a read transfer, `ser_dout` equals the inverse of `key_pending`. While `hold` is high, `ser_dout` is 1.
- R8: A read transfer uses address 8FH (bit sequence 1,1,1,1,0,0,0,1). If `key_pending` is high and `hold` is low when `ser_ce` rises, `ser_dout` presents `key_bits[0]` from then on. It advances one bit on each falling `ser_clk` edge. The host sampling on rising edges sees `key_bits[0..29]`, then `sleep_ack`.
- R9: `key_read_done` pulses for exactly one cycle when `ser_ce` falls after a served read transfer of exactly 31 data bits. A shorter read gives no pulse.
- R10: A read transfer started with `key_pending` low, or during `hold`, returns all ones and gives no `key_read_done`.
- R11: Read transfers leave `seg_data`, `sleep_ctl` and `dim_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Display hold: blanks the display and suppresses key readout |
| ser_clk | input | 1 | Serial shift clock from the host, idles low |
| ser_ce | input | 1 | Chip-enable: low for the address, high for the data phase |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Open-drain level toward the host (1 = released) |
| key_bits | input | 30 | Key matrix result from the scanner |
| key_pending | input | 1 | Scanner has unread key data |
| sleep_ack | input | 1 | Scanner saw a press during sleep |
| seg_data | output | 82 | Latched segment pattern |
| sleep_ctl | output | 2 | Latched sleep control pair |
| dim_val | output | 10 | Latched dimmer value |
| disp_on | output | 1 | Display enable, low during hold |
| key_read_done | output | 1 | One-cycle strobe after a complete key readout |

## Verification
The hardest situations to reach from the ports are transfers that differ from a valid one by a single bit. A write one bit short or long, a read stopped one bit early, or an address one bit off must all be rejected while neighbouring frames are accepted. The stimulus mixes random write contents with randomly chosen lengths of 93, 95 or 94 bits and randomly corrupted addresses. Read transfers are interleaved with `key_pending` randomly high or low, so served, unserved and truncated reads alternate around the same latched state.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  localparam int          ADDR_BITS = 8;
  localparam logic [7:0]  WR_ADDR   = 8'h8E;
  localparam logic [7:0]  RD_ADDR   = 8'h8F;

  typedef enum logic [1:0] {
    FR_NONE  = 2'd0,
    FR_WRITE = 2'd1,
    FR_READ  = 2'd2
  } frame_kind_t;
endpackage

// File: rtl/vsp_sync.sv
module vsp_sync #(
  parameter int W      = 3,
  parameter int EW     = 2,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  async_in,
  output logic [W-1:0]  lvl,
  output logic [EW-1:0] prv
);
  for (genvar i = 0; i < W; i++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_in[i]};
    end
    assign lvl[i] = chain[STAGES-1];
  end

  for (genvar j = 0; j < EW; j++) begin : g_prev
    logic p;
    always_ff @(posedge clk) begin
      if (rst) p <= 1'b0;
      else     p <= lvl[j];
    end
    assign prv[j] = p;
  end
endmodule

// File: rtl/vsp_rx.sv
module vsp_rx
  import vsp_pkg::*;
#(
  parameter int SEG_W = 82,
  parameter int SLP_W = 2,
  parameter int DIM_W = 10,
  parameter int KEY_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_rise,
  input  logic             ce_lvl,
  input  logic             ce_rise,
  input  logic             ce_fall,
  input  logic             din,
  output logic [SEG_W-1:0] seg_q,
  output logic [SLP_W-1:0] slp_q,
  output logic [DIM_W-1:0] dim_q,
  output logic             wr_commit,
  output logic             rd_start,
  output logic             rd_stop,
  output logic             rd_full
);
  localparam int WR_BITS = SEG_W + SLP_W + DIM_W;
  localparam int RD_BITS = KEY_W + 1;
  localparam int MAXB    = (WR_BITS > RD_BITS) ? WR_BITS : RD_BITS;
  localparam int CW      = $clog2(MAXB + 2);
  localparam int AW      = $clog2(ADDR_BITS + 2);
  localparam logic [CW-1:0] WR_N    = CW'(WR_BITS);
  localparam logic [CW-1:0] RD_N    = CW'(RD_BITS);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAXB + 1);
  localparam logic [AW-1:0] ADR_N   = AW'(ADDR_BITS);
  localparam logic [AW-1:0] ADR_MAX = AW'(ADDR_BITS + 1);

  logic [ADDR_BITS-1:0] addr_sr;
  logic [AW-1:0]        addr_cnt;
  logic [WR_BITS-1:0]   data_sr;
  logic [CW-1:0]        data_cnt;
  frame_kind_t          kind;
  frame_kind_t          next_kind;

  always_comb begin
    next_kind = FR_NONE;
    if (addr_cnt == ADR_N) begin
      if (addr_sr == WR_ADDR)      next_kind = FR_WRITE;
      else if (addr_sr == RD_ADDR) next_kind = FR_READ;
    end
  end

  // staging shift register, no reset: only copied out after a full count
  always_ff @(posedge clk) begin
    if (sclk_rise && ce_lvl && kind == FR_WRITE)
      data_sr <= {din, data_sr[WR_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    wr_commit <= 1'b0;
    rd_start  <= 1'b0;
    rd_stop   <= 1'b0;
    rd_full   <= 1'b0;
    if (rst) begin
      addr_sr  <= '0;
      addr_cnt <= '0;
      data_cnt <= '0;
      kind     <= FR_NONE;
      seg_q    <= '0;
      slp_q    <= '0;
      dim_q    <= '0;
    end else if (ce_rise) begin
      kind     <= next_kind;
      data_cnt <= '0;
      rd_start <= (next_kind == FR_READ);
    end else if (ce_fall) begin
      if (kind == FR_WRITE && data_cnt == WR_N) begin
        seg_q     <= data_sr[SEG_W-1:0];
        slp_q     <= data_sr[SEG_W+SLP_W-1:SEG_W];
        dim_q     <= data_sr[WR_BITS-1:SEG_W+SLP_W];
        wr_commit <= 1'b1;
      end
      if (kind == FR_READ) begin
        rd_stop <= 1'b1;
        rd_full <= (data_cnt == RD_N);
      end
      kind     <= FR_NONE;
      addr_cnt <= '0;
    end else if (sclk_rise) begin
      if (ce_lvl) begin
        if (data_cnt != CNT_MAX) data_cnt <= data_cnt + 1'b1;
      end else begin
        addr_sr <= {din, addr_sr[ADDR_BITS-1:1]};
        if (addr_cnt != ADR_MAX) addr_cnt <= addr_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vsp_tx.sv
module vsp_tx #(
  parameter int KEY_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [KEY_W-1:0] key_bits,
  input  logic             key_pending,
  input  logic             sleep_ack,
  input  logic             rd_start,
  input  logic             rd_stop,
  input  logic             rd_full,
  input  logic             sclk_fall,
  output logic             dout,
  output logic             done,
  output logic             active
);
  localparam int RD_BITS = KEY_W + 1;

  logic [RD_BITS-1:0] sr;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      active <= 1'b0;
      sr     <= '1;
      dout   <= 1'b1;
    end else begin
      if (rd_start) begin
        active <= key_pending && !hold;
        sr     <= {sleep_ack, key_bits};
      end else if (rd_stop) begin
        active <= 1'b0;
        done   <= active && rd_full;
      end else if (sclk_fall && active) begin
        sr <= {1'b1, sr[RD_BITS-1:1]};
      end
      if (hold)        dout <= 1'b1;
      else if (active) dout <= sr[0];
      else             dout <= !key_pending;
    end
  end
endmodule

// File: rtl/vsp_serial_port.sv
module vsp_serial_port #(
  parameter int SEG_W = 82,
  parameter int SLP_W = 2,
  parameter int DIM_W = 10,
  parameter int KEY_W = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             ser_clk,
  input  logic             ser_ce,
  input  logic             ser_din,
  output logic             ser_dout,
  input  logic [KEY_W-1:0] key_bits,
  input  logic             key_pending,
  input  logic             sleep_ack,
  output logic [SEG_W-1:0] seg_data,
  output logic [SLP_W-1:0] sleep_ctl,
  output logic [DIM_W-1:0] dim_val,
  output logic             disp_on,
  output logic             key_read_done
);
  localparam int PIN_SCLK = 0;
  localparam int PIN_CE   = 1;
  localparam int PIN_DIN  = 2;

  logic [2:0] pin_lvl;
  logic [1:0] pin_prv;
  logic sclk_rise, sclk_fall, ce_rise, ce_fall;
  logic wr_commit, rd_start, rd_stop, rd_full, rd_active;

  vsp_sync #(.W(3), .EW(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({ser_din, ser_ce, ser_clk}),
    .lvl      (pin_lvl),
    .prv      (pin_prv)
  );

  assign sclk_rise =  pin_lvl[PIN_SCLK] & ~pin_prv[PIN_SCLK];
  assign sclk_fall = ~pin_lvl[PIN_SCLK] &  pin_prv[PIN_SCLK];
  assign ce_rise   =  pin_lvl[PIN_CE]   & ~pin_prv[PIN_CE];
  assign ce_fall   = ~pin_lvl[PIN_CE]   &  pin_prv[PIN_CE];

  vsp_rx #(.SEG_W(SEG_W), .SLP_W(SLP_W), .DIM_W(DIM_W), .KEY_W(KEY_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .ce_lvl    (pin_lvl[PIN_CE]),
    .ce_rise   (ce_rise),
    .ce_fall   (ce_fall),
    .din       (pin_lvl[PIN_DIN]),
    .seg_q     (seg_data),
    .slp_q     (sleep_ctl),
    .dim_q     (dim_val),
    .wr_commit (wr_commit),
    .rd_start  (rd_start),
    .rd_stop   (rd_stop),
    .rd_full   (rd_full)
  );

  vsp_tx #(.KEY_W(KEY_W)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .hold        (hold),
    .key_bits    (key_bits),
    .key_pending (key_pending),
    .sleep_ack   (sleep_ack),
    .rd_start    (rd_start),
    .rd_stop     (rd_stop),
    .rd_full     (rd_full),
    .sclk_fall   (sclk_fall),
    .dout        (ser_dout),
    .done        (key_read_done),
    .active      (rd_active)
  );

  always_ff @(posedge clk) begin
    if (rst) disp_on <= 1'b0;
    else     disp_on <= !hold;
  end
endmodule

// File: rtl/vsp_checker.sv
module vsp_checker #(
  parameter int SEG_W = 82,
  parameter int SLP_W = 2,
  parameter int DIM_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             hold,
  input logic             ser_dout,
  input logic             disp_on,
  input logic             key_read_done,
  input logic             wr_commit,
  input logic             rd_active,
  input logic [SEG_W-1:0] seg_data,
  input logic [SLP_W-1:0] sleep_ctl,
  input logic [DIM_W-1:0] dim_val
);
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit); // R2
  AST_REG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$stable({seg_data, sleep_ctl, dim_val}) |-> wr_commit); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    key_read_done |=> !key_read_done); // R9
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    key_read_done |-> $past(rd_active)); // R9
  AST_HOLD_DOUT: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> ser_dout); // R7
  AST_HOLD_DISP: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> !disp_on); // R6
endmodule

bind vsp_serial_port vsp_checker #(.SEG_W(SEG_W), .SLP_W(SLP_W), .DIM_W(DIM_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .hold          (hold),
  .ser_dout      (ser_dout),
  .disp_on       (disp_on),
  .key_read_done (key_read_done),
  .wr_commit     (wr_commit),
  .rd_active     (rd_active),
  .seg_data      (seg_data),
  .sleep_ctl     (sleep_ctl),
  .dim_val       (dim_val)
);

// File: tb/sim_vsp_serial_port.sv
`timescale 1ns/1ps
module sim_vsp_serial_port;
  localparam int HP = 8;

  logic clk = 1'b0, rst = 1'b1, hold = 1'b0;
  logic ser_clk = 1'b0, ser_ce = 1'b0, ser_din = 1'b0;
  logic [29:0] key_bits = '0;
  logic key_pending = 1'b0, sleep_ack = 1'b0;
  wire ser_dout, disp_on, key_read_done;
  wire [81:0] seg_data;
  wire [1:0]  sleep_ctl;
  wire [9:0]  dim_val;

  vsp_serial_port u0 (
    .clk(clk), .rst(rst), .hold(hold), .ser_clk(ser_clk), .ser_ce(ser_ce),
    .ser_din(ser_din), .ser_dout(ser_dout), .key_bits(key_bits),
    .key_pending(key_pending), .sleep_ack(sleep_ack), .seg_data(seg_data),
    .sleep_ctl(sleep_ctl), .dim_val(dim_val), .disp_on(disp_on),
    .key_read_done(key_read_done)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, done_cnt = 0;
  logic [81:0]  seg_e = '0;
  logic [1:0]   slp_e = '0;
  logic [9:0]   dim_e = '0;
  logic [127:0] rd_cap;

  always @(negedge clk) if (key_read_done) done_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] pack(input logic [81:0] s, input logic [1:0] p, input logic [9:0] d);
    return {34'b0, d, p, s};
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b);
    ser_din = b; waitc(HP); ser_clk = 1'b1; waitc(HP); ser_clk = 1'b0;
  endtask

  task automatic send_addr(input logic [7:0] a);
    ser_ce = 1'b0;
    for (int i = 0; i < 8; i++) ser_bit(a[i]);
    waitc(HP); ser_ce = 1'b1; waitc(HP);
  endtask

  task automatic end_frame;
    waitc(HP); ser_ce = 1'b0; waitc(12);
  endtask

  task automatic write_frame(input logic [7:0] a, input int n, input logic [127:0] bits);
    send_addr(a);
    for (int k = 0; k < n; k++) ser_bit(bits[k]);
    end_frame();
  endtask

  task automatic read_frame(input logic [7:0] a, input int n);
    send_addr(a);
    rd_cap = '1;
    for (int k = 0; k < n; k++) begin
      waitc(HP); rd_cap[k] = ser_dout; ser_clk = 1'b1; waitc(HP); ser_clk = 1'b0;
    end
    end_frame();
  endtask

  task automatic check_regs(input string tag);
    chk(seg_data == seg_e, tag, 128'(seg_data), 128'(seg_e));
    chk(sleep_ctl == slp_e, tag, 128'(sleep_ctl), 128'(slp_e));
    chk(dim_val == dim_e, tag, 128'(dim_val), 128'(dim_e));
  endtask

  function automatic logic [81:0] rnd_seg();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[81:0];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed0;
    int base;
    seed0 = $urandom(32'h5EED1234);
    waitc(5);
    // R1 reset state
    chk(seg_data == '0 && sleep_ctl == '0 && dim_val == '0, "R1 regs", 128'(seg_data), 0);
    chk(ser_dout == 1'b1 && disp_on == 1'b0 && key_read_done == 1'b0, "R1 outs",
        {ser_dout, disp_on, key_read_done}, 3'b100);
    rst = 1'b0; waitc(10);

    // R2 single segment bit D1
    seg_e = 82'h1;
    write_frame(8'h8E, 94, pack(seg_e, slp_e, dim_e));
    check_regs("R2 d1");
    seg_e = 82'h2_0000_0000_0000_0000_0001;
    write_frame(8'h8E, 94, pack(seg_e, slp_e, dim_e));
    check_regs("R2 ends");

    // R3 sleep and dimmer positions
    slp_e = 2'b10; dim_e = 10'h201;
    write_frame(8'h8E, 94, pack(seg_e, slp_e, dim_e));
    check_regs("R3 slp dim");

    // R4 wrong lengths
    write_frame(8'h8E, 93, pack(~seg_e, ~slp_e, ~dim_e));
    check_regs("R4 short");
    write_frame(8'h8E, 95, pack(~seg_e, ~slp_e, ~dim_e));
    check_regs("R4 long");

    // R5 unknown address
    base = done_cnt;
    write_frame(8'h8D, 94, pack(~seg_e, ~slp_e, ~dim_e));
    check_regs("R5 bad addr");
    chk(done_cnt == base, "R5 no done", done_cnt, base);

    // R7 idle request line
    key_pending = 1'b1; waitc(4);
    chk(ser_dout == 1'b0, "R7 pending", ser_dout, 0);
    key_pending = 1'b0; waitc(4);
    chk(ser_dout == 1'b1, "R7 idle", ser_dout, 1);

    // R8 R9 served read
    key_bits = 30'h2A5C_3E17; sleep_ack = 1'b1; key_pending = 1'b1;
    base = done_cnt;
    read_frame(8'h8F, 31);
    chk(rd_cap[30:0] == {sleep_ack, key_bits}, "R8 data", 128'(rd_cap[30:0]), 128'({sleep_ack, key_bits}));
    chk(done_cnt == base + 1, "R9 done", done_cnt, base + 1);
    key_pending = 1'b0;

    // R9 short read
    key_pending = 1'b1; key_bits = 30'h0F0F_1234; sleep_ack = 1'b0;
    base = done_cnt;
    read_frame(8'h8F, 30);
    chk(rd_cap[29:0] == key_bits, "R9 short data", 128'(rd_cap[29:0]), 128'(key_bits));
    chk(done_cnt == base, "R9 short no done", done_cnt, base);
    key_pending = 1'b0;

    // R10 unserved read
    base = done_cnt;
    read_frame(8'h8F, 31);
    chk(rd_cap[30:0] == '1, "R10 ones", 128'(rd_cap[30:0]), 128'(31'h7FFF_FFFF));
    chk(done_cnt == base, "R10 no done", done_cnt, base);
    check_regs("R11 after reads");

    // R6 hold
    hold = 1'b1; key_pending = 1'b1; waitc(4);
    chk(disp_on == 1'b0, "R6 blank", disp_on, 0);
    chk(ser_dout == 1'b1, "R7 hold", ser_dout, 1);
    seg_e = rnd_seg(); slp_e = 2'b01; dim_e = 10'h3FE;
    write_frame(8'h8E, 94, pack(seg_e, slp_e, dim_e));
    check_regs("R6 write in hold");
    base = done_cnt;
    read_frame(8'h8F, 31);
    chk(rd_cap[30:0] == '1 && done_cnt == base, "R10 hold read", 128'(rd_cap[30:0]), 128'(31'h7FFF_FFFF));
    hold = 1'b0; waitc(4);
    chk(disp_on == 1'b1, "R6 release", disp_on, 1);
    chk(ser_dout == 1'b0, "R7 after hold", ser_dout, 0);
    key_pending = 1'b0; waitc(4);

    // random mix
    for (int it = 0; it < 20; it++) begin
      int op;
      op = int'($urandom() % 4);
      if (op == 0) begin
        seg_e = rnd_seg(); slp_e = 2'($urandom()); dim_e = 10'($urandom());
        write_frame(8'h8E, 94, pack(seg_e, slp_e, dim_e));
        check_regs("R2 R3 random write");
      end else if (op == 1) begin
        logic [7:0] a;
        int n;
        a = 8'h8E; n = 94;
        if ($urandom() % 2 == 0) a = a ^ (8'h1 << ($urandom() % 8));
        else n = ($urandom() % 2 == 0) ? 93 : 95;
        if (a == 8'h8F) a = 8'h0F;
        write_frame(a, n, pack(rnd_seg(), 2'($urandom()), 10'($urandom())));
        check_regs("R4 R5 random reject");
      end else begin
        int n;
        logic [30:0] exp;
        key_bits = 30'($urandom()); sleep_ack = 1'($urandom());
        key_pending = 1'($urandom());
        n = (op == 2) ? 31 : 30;
        exp = key_pending ? {sleep_ack, key_bits} : '1;
        if (n == 30) exp[30] = 1'b1;
        base = done_cnt;
        read_frame(8'h8F, n);
        chk(rd_cap[30:0] == exp, "R8 R10 random read", 128'(rd_cap[30:0]), 128'(exp));
        chk(done_cnt == base + ((key_pending && n == 31) ? 1 : 0), "R9 random done", done_cnt,
            base + ((key_pending && n == 31) ? 1 : 0));
        key_pending = 1'b0;
        check_regs("R11 random read");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule